// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Pin Interrupts

This block is a general-purpose I/O controller for 22 pins, reached through a word-addressed register port with 32-bit data. Software drives pin output levels through a value register or through separate write-one-to-set and write-one-to-clear registers. It controls each pin's direction with an output-enable bit. It reads back pin levels after a two-flop synchroniser. It also picks each pin's two-bit alternate-function index from two bit-plane registers: one holds the low bit of every pin's index, the other the high bit. The indices leave the block on a packed output bus for the pad-side mux, and index 0 means plain GPIO.

Every synchronised input feeds an event detector. A pin in edge mode flags any change between successive synchronised samples. A pin in level mode flags every cycle in which its synchronised input is high. A flagged event sets a sticky pending bit, which software clears by writing one to it. An identity view shows the pending bits that are also enabled, and a single registered interrupt line is raised while any of them is set.

The register port is plain control, not a data stream. It has no valid/ready pair and no back-pressure: a write or read strobe is accepted in the cycle it is presented. Read data appears on the clock edge after the read strobe and holds until the next read.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every register reads zero, and pin_out, pin_oe, pin_func and irq are all zero.
- R2: A write to word 2 (byte 0x08) loads the output value. A write to byte 0x00 sets the output bits written as 1, and a write to byte 0x04 clears them. Bits written as 0 leave the output unchanged. The set and clear words read as zero.
- R3: Byte 0x10 holds the output enables. pin_oe[i] is bit i of that register, and 1 means the pin drives.
- R4: Byte 0x20 holds function-index bit 0 and byte 0x24 holds bit 1 for every pin. pin_func[2i+1:2i] equals {bit i of 0x24, bit i of 0x20}.
- R5: Byte 0x0C is read-only and returns pin_in after two synchroniser flops. A pin change made before clock edge k is returned by a read strobed at edge k+2 or later.
- R6: In edge mode (bit of byte 0x2C = 0) any change of a synchronised input sets that pin's pending bit at byte 0x14 on the edge after the synchronised value changes.
- R7: In level mode (bit of byte 0x2C = 1) the pending bit is set again on every edge while the synchronised input is high.
- R8: Writing 1 to a pending bit clears it. If an event for the same pin arrives in the same cycle, the event wins and the bit stays set.
- R9: Byte 0x18 holds interrupt enables. Byte 0x1C reads pending AND enable. irq is one when that AND was non-zero at the previous edge.
- R10: Bits 31 to 22 of every register read zero and ignore writes. Unmapped words (byte 0x28 and 0x30 to 0x3C) read zero and ignore writes.
- R11: bus_rdata changes only on an edge where bus_rd is high. It then holds the addressed register's value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 22 | Raw pin levels, asynchronous |
| pin_out | output | 22 | Output levels |
| pin_oe | output | 22 | Output enables |
| pin_func | output | 44 | Two-bit function index per pin |
| irq | output | 1 | Aggregate interrupt |

## Verification
A wrong output, enable or function register shows on pin_out, pin_oe or pin_func on the first falling edge after the write. A wrong synchroniser or edge detector shows up three edges after a pin change, when the pending register is read back. A pending bit that sets wrongly or fails to clear also reaches irq one edge later when it is enabled. The bench's per-cycle reference model therefore sees any divergence within a few cycles of the stimulus that caused it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    RG_SET   = 4'd0,
    RG_CLR   = 4'd1,
    RG_VAL   = 4'd2,
    RG_IN    = 4'd3,
    RG_OE    = 4'd4,
    RG_PEND  = 4'd5,
    RG_IEN   = 4'd6,
    RG_IDENT = 4'd7,
    RG_FS0   = 4'd8,
    RG_FS1   = 4'd9,
    RG_SENSE = 4'd11
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int NPIN  = 22,
  parameter int DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] s_now,
  output logic [NPIN-1:0] s_prev
);
  localparam int LAST = DEPTH;

  // chain[0..DEPTH-1] synchronise, chain[DEPTH] keeps the previous sample
  logic [NPIN-1:0] chain [LAST+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s <= LAST; s++) chain[s] <= '0;
    end else begin
      chain[0] <= pin_in;
      for (int s = 1; s <= LAST; s++) chain[s] <= chain[s-1];
    end
  end

  assign s_now  = chain[LAST-1];
  assign s_prev = chain[LAST];
endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
  parameter int NPIN = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] s_now,
  input  logic [NPIN-1:0] s_prev,
  input  logic [NPIN-1:0] sense,
  input  logic [NPIN-1:0] ack_mask,
  output logic [NPIN-1:0] hit,
  output logic [NPIN-1:0] pend_q
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    // level mode: high input; edge mode: any change
    assign hit[p] = sense[p] ? s_now[p] : (s_now[p] ^ s_prev[p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= hit | (pend_q & ~ack_mask);
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int NPIN = 22,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pend,
  input  logic [NPIN-1:0] s_now,
  output logic [NPIN-1:0] out_q,
  output logic [NPIN-1:0] oe_q,
  output logic [NPIN-1:0] fsel0_q,
  output logic [NPIN-1:0] fsel1_q,
  output logic [NPIN-1:0] ien_q,
  output logic [NPIN-1:0] sense_q,
  output logic [NPIN-1:0] ack_mask
);
  localparam int WW  = AW - 2;
  localparam int PAD = DW - NPIN;

  logic [WW-1:0]   widx;
  logic [NPIN-1:0] wbits;
  logic [NPIN-1:0] rsel;

  assign widx  = bus_addr[AW-1:2];
  assign wbits = bus_wdata[NPIN-1:0];

  function automatic logic wr_hit(input logic [WW-1:0] idx, input gpio_reg_e r);
    return idx == WW'(r);
  endfunction

  // output value: direct load, set and clear words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else if (bus_wr) begin
      if (wr_hit(widx, RG_VAL))      out_q <= wbits;
      else if (wr_hit(widx, RG_SET)) out_q <= out_q | wbits;
      else if (wr_hit(widx, RG_CLR)) out_q <= out_q & ~wbits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= '0;
      fsel0_q <= '0;
      fsel1_q <= '0;
      ien_q   <= '0;
      sense_q <= '0;
    end else if (bus_wr) begin
      if (wr_hit(widx, RG_OE))    oe_q    <= wbits;
      if (wr_hit(widx, RG_FS0))   fsel0_q <= wbits;
      if (wr_hit(widx, RG_FS1))   fsel1_q <= wbits;
      if (wr_hit(widx, RG_IEN))   ien_q   <= wbits;
      if (wr_hit(widx, RG_SENSE)) sense_q <= wbits;
    end
  end

  assign ack_mask = (bus_wr && wr_hit(widx, RG_PEND)) ? wbits : '0;

  always_comb begin
    rsel = '0;
    if      (wr_hit(widx, RG_VAL))   rsel = out_q;
    else if (wr_hit(widx, RG_IN))    rsel = s_now;
    else if (wr_hit(widx, RG_OE))    rsel = oe_q;
    else if (wr_hit(widx, RG_PEND))  rsel = pend;
    else if (wr_hit(widx, RG_IEN))   rsel = ien_q;
    else if (wr_hit(widx, RG_IDENT)) rsel = pend & ien_q;
    else if (wr_hit(widx, RG_FS0))   rsel = fsel0_q;
    else if (wr_hit(widx, RG_FS1))   rsel = fsel1_q;
    else if (wr_hit(widx, RG_SENSE)) rsel = sense_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {{PAD{1'b0}}, rsel};
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
  parameter int NPIN = 22,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [2*NPIN-1:0] pin_func,
  output logic              irq
);
  logic [NPIN-1:0] s_now, s_prev, hit, pend_q, ack_mask;
  logic [NPIN-1:0] out_q, oe_q, fsel0_q, fsel1_q, ien_q, sense_q;

  gpio_sync #(.NPIN(NPIN), .DEPTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .s_now(s_now), .s_prev(s_prev)
  );

  gpio_event #(.NPIN(NPIN)) u_event (
    .clk(clk), .rst_n(rst_n), .s_now(s_now), .s_prev(s_prev), .sense(sense_q),
    .ack_mask(ack_mask), .hit(hit), .pend_q(pend_q)
  );

  gpio_regfile #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend(pend_q), .s_now(s_now), .out_q(out_q), .oe_q(oe_q),
    .fsel0_q(fsel0_q), .fsel1_q(fsel1_q), .ien_q(ien_q), .sense_q(sense_q),
    .ack_mask(ack_mask)
  );

  assign pin_out = out_q;
  assign pin_oe  = oe_q;

  for (genvar p = 0; p < NPIN; p++) begin : g_func
    assign pin_func[2*p +: 2] = {fsel1_q[p], fsel0_q[p]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(pend_q & ien_q);
  end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int NPIN = 22,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq,
  input logic [NPIN-1:0] pend,
  input logic [NPIN-1:0] ien,
  input logic [NPIN-1:0] sense,
  input logic [NPIN-1:0] s_now
);
  localparam int WW = AW - 2;
  logic [WW-1:0] widx;
  assign widx = bus_addr[AW-1:2];

  a_r2_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == WW'(0)) |=>
      ((pin_out & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

  a_r2_clr_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == WW'(1)) |=> ((pin_out & $past(bus_wdata[NPIN-1:0])) == '0));

  a_r3_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && widx == WW'(4)) |=> $stable(pin_oe));

  a_r7_level_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(sense & s_now)) == $past(sense & s_now)));

  a_r9_irq_tracks_ident: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(pend & ien))));

  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NPIN] == '0);
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPIN(NPIN), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq(irq), .pend(pend_q), .ien(ien_q), .sense(sense_q),
  .s_now(s_now)
);

// File: tb/test_gpio_ctrl.sv
`timescale 1ns/1ps
module test_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [21:0] pin_in = '0;
  logic [21:0] pin_out, pin_oe;
  logic [43:0] pin_func;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit model_on = 0;

  always #4 clk = ~clk;

  gpio_ctrl i_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_func(pin_func), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [21:0] m_out, m_oe, m_f0, m_f1, m_pend, m_en, m_sense, m_s1, m_s2, m_s3;
  logic [31:0] m_rdata;
  logic        m_irq;

  function automatic logic [21:0] m_read(input int w);
    case (w)
      2: return m_out;
      3: return m_s2;
      4: return m_oe;
      5: return m_pend;
      6: return m_en;
      7: return m_pend & m_en;
      8: return m_f0;
      9: return m_f1;
      11: return m_sense;
      default: return 22'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_oe = 0; m_f0 = 0; m_f1 = 0; m_pend = 0; m_en = 0;
      m_sense = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rdata = 0; m_irq = 0;
    end else begin
      automatic int w = int'(bus_addr[5:2]);
      automatic logic [21:0] d = bus_wdata[21:0];
      automatic logic [21:0] ev = 0;
      automatic logic [21:0] ack = 0;
      for (int i = 0; i < 22; i++)
        ev[i] = m_sense[i] ? m_s2[i] : (m_s2[i] != m_s3[i]);
      if (bus_wr && w == 5) ack = d;
      if (bus_rd) m_rdata = {10'd0, m_read(w)};
      m_irq  = (m_pend & m_en) != 0;
      m_pend = ev | (m_pend & ~ack);
      if (bus_wr) begin
        case (w)
          0: m_out = m_out | d;
          1: m_out = m_out & ~d;
          2: m_out = d;
          4: m_oe = d;
          6: m_en = d;
          8: m_f0 = d;
          9: m_f1 = d;
          11: m_sense = d;
          default: ;
        endcase
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      automatic logic [43:0] fexp = 0;
      for (int i = 0; i < 22; i++) fexp[2*i +: 2] = {m_f1[i], m_f0[i]};
      chk("R2 pin_out vs model", 64'(pin_out), 64'(m_out));
      chk("R3 pin_oe vs model", 64'(pin_oe), 64'(m_oe));
      chk("R4 pin_func vs model", 64'(pin_func), 64'(fexp));
      chk("R9 irq vs model", 64'(irq), 64'(m_irq));
      chk("R11 rdata vs model", 64'(bus_rdata), 64'(m_rdata));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    model_on = 1;
    idle(1);
    // R1 reset state
    chk("R1 pin_out reset", 64'(pin_out), 64'd0);
    chk("R1 irq reset", 64'(irq), 64'd0);
    rd(6'h08, 32'h0, "R1 value reg reset");
    rd(6'h1C, 32'h0, "R1 identity reset");
    // R10 upper bits dropped
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, 32'h003F_FFFF, "R10 upper bits read zero");
    // R2 set / clear
    wr(6'h04, 32'h0000_000F);
    chk("R2 clear low nibble", 64'(pin_out), 64'h3F_FFF0);
    wr(6'h00, 32'h0000_0003);
    chk("R2 set two bits", 64'(pin_out), 64'h3F_FFF3);
    wr(6'h00, 32'h0);
    chk("R2 zero set is no-op", 64'(pin_out), 64'h3F_FFF3);
    rd(6'h00, 32'h0, "R2 set word reads zero");
    // R3 output enable
    wr(6'h10, 32'h0015_5555);
    chk("R3 pin_oe", 64'(pin_oe), 64'h15_5555);
    // R4 function select bit planes
    wr(6'h20, 32'h1);
    wr(6'h24, 32'h3);
    chk("R4 pin_func low pins", 64'(pin_func[3:0]), 64'hB);
    // R10 unmapped word
    wr(6'h30, 32'hFFFF_FFFF);
    rd(6'h30, 32'h0, "R10 unmapped reads zero");
    chk("R10 unmapped write ignored", 64'(pin_out), 64'h3F_FFF3);
    // R5 synchronised input
    @(negedge clk); pin_in = 22'h2A5;
    idle(1);
    rd(6'h0C, 32'h2A5, "R5 input after two flops");
    idle(3);
    wr(6'h14, 32'h003F_FFFF);
    rd(6'h14, 32'h0, "R8 pending cleared");
    // R6 edge events, R9 identity and irq
    wr(6'h18, 32'h20);
    @(negedge clk); pin_in = 22'h085;
    idle(4);
    chk("R9 irq raised", 64'(irq), 64'd1);
    rd(6'h14, 32'h220, "R6 edges pending");
    rd(6'h1C, 32'h20, "R9 identity masked");
    wr(6'h14, 32'h220);
    idle(1);
    chk("R9 irq dropped", 64'(irq), 64'd0);
    // R7 level mode and R8 collision
    wr(6'h2C, 32'h80);
    idle(2);
    wr(6'h14, 32'h80);
    rd(6'h14, 32'h80, "R8 event beats clear");
    @(negedge clk); pin_in = 22'h005;
    idle(4);
    wr(6'h14, 32'h80);
    rd(6'h14, 32'h0, "R7 level low stays clear");
    // R11 read data hold
    rd(6'h08, 32'h3F_FFF3, "R11 read value");
    idle(2);
    chk("R11 rdata holds", 64'(bus_rdata), 64'h3F_FFF3);
    // mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      bus_wr    = ($urandom % 3) == 0;
      bus_rd    = ($urandom % 2) == 0;
      bus_addr  = 6'(($urandom % 16) * 4);
      bus_wdata = $urandom;
      if (($urandom % 5) == 0) pin_in = 22'($urandom);
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    idle(4);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule